// File: doc/BRIEF.md
# Non-Coherent Power Integrator and Peak Detector

This block sits behind a correlator in a satellite-signal acquisition chain. For every delay/Doppler cell it receives the complex result of a coherent correlation and forms its energy with a square-law detector, I² + Q². The square-law step removes the unknown carrier phase. The energy of each cell is kept in an on-chip array with one word per cell. The first pass of an integration overwrites the array and each later pass adds to it. The number of passes is programmable, for example 1 for a short search and 7 for a weak-signal search.

Two signal types are handled. For plain phase-shift-keyed spreading, only channel 0 contributes. For binary-offset-carrier spreading, channel 0 holds the correlation against the code times the sign of the subcarrier sine and channel 1 holds the correlation against the code times minus the sign of the subcarrier cosine. Adding the energies of both channels gives a single unambiguous correlation peak.

During the last pass the block tracks the strongest cell. After the final cell it emits a one-cycle completion pulse together with the index of the strongest cell, its accumulated energy, and a detection flag that compares that energy with a programmable threshold.

Top module: `ncoh_detect`

## Requirements
- R1: In single-channel mode (`mode_boc`=0) the energy of a beat is ch0_i² + ch0_q², treating each input as a 16-bit two's-complement value; channel 1 has no effect.
- R2: In two-channel mode (`mode_boc`=1) the energy of a beat is ch0_i² + ch0_q² + ch1_i² + ch1_q².
- R3: On the first pass the stored value of a cell becomes the beat energy and the previous content is ignored; on every later pass the beat energy is added to the stored value.
- R4: An accumulation that would exceed the accumulator width saturates at the all-ones value instead of wrapping.
- R5: An integration begins with a beat that has `in_pass_start`=1 while the block is idle. `n_pass` is sampled on that beat, and a value of 0 is treated as 1. Each later beat with `in_pass_start`=1 begins the next pass.
- R6: `done` is a single-cycle pulse. It is high in the cycle that follows the third rising edge after the beat with bin index NBINS-1 of the last pass is accepted, and it is never high at any other time.
- R7: `peak_idx` and `peak_val` give the cell with the largest accumulated value after the last pass; when cells tie, the lowest index (the first one seen) is kept.
- R8: `detect` is 1 exactly when `peak_val` ≥ `thresh`, with `thresh` taken at the edge that raises `done`.
- R9: After reset, `done`, `peak_idx`, `peak_val` and `detect` are all 0. Valid beats that arrive while idle without `in_pass_start` are ignored and leave later results unchanged.
- R10: `peak_idx`, `peak_val` and `detect` change only on the edge that raises `done`, and they hold their values between pulses, even while a new integration is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat qualifier |
| in_pass_start | input | 1 | Marks the first beat (bin 0) of a pass |
| in_bin | input | $clog2(NBINS) | Cell index, ascending within a pass |
| mode_boc | input | 1 | 0: single channel, 1: two-channel sum |
| n_pass | input | PASS_W | Number of non-coherent passes (0 means 1) |
| thresh | input | ACC_W | Detection threshold |
| ch0_i | input | SAMP_W | Channel 0 in-phase, signed |
| ch0_q | input | SAMP_W | Channel 0 quadrature, signed |
| ch1_i | input | SAMP_W | Channel 1 in-phase, signed |
| ch1_q | input | SAMP_W | Channel 1 quadrature, signed |
| done | output | 1 | Completion pulse |
| peak_idx | output | $clog2(NBINS) | Index of the strongest cell |
| peak_val | output | ACC_W | Accumulated energy of the strongest cell |
| detect | output | 1 | Peak reached the threshold |

## Verification
Two functions can fall in the same cycle. First, the peak tracker can take a new maximum on the final cell in the same edge where it publishes the result. Second, the first pass of the next integration can begin while the completion of the previous one is still in the pipeline. The bench provokes both together: it places the largest energy on the last cell, then starts the next integration on the very next cycle with no idle gap. A behavioural reference model with a three-beat delay queue is compared on every clock, so the published index must be the final cell, and the held outputs must not be disturbed by the overlapping first-pass writes.

// File: rtl/ncoh_pkg.sv
package ncoh_pkg;

  localparam int NCH = 2;

  typedef enum logic {
    MODE_BPSK = 1'b0,
    MODE_BOC  = 1'b1
  } ncoh_mode_e;

  typedef struct packed {
    logic valid;
    logic first;
    logic last;
    logic pstart;
    logic endbin;
  } beat_flags_t;

endpackage

// File: rtl/ncoh_power.sv
module ncoh_power #(
  parameter int SAMP_W = 16,
  localparam int PWR_W = 2 * SAMP_W + 1
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   in_valid,
  input  logic                                   boc,
  input  logic [ncoh_pkg::NCH-1:0][SAMP_W-1:0]   i_vec,
  input  logic [ncoh_pkg::NCH-1:0][SAMP_W-1:0]   q_vec,
  output logic [PWR_W-1:0]                       pwr
);
  import ncoh_pkg::*;

  localparam int SQ_W = 2 * SAMP_W;

  logic [NCH-1:0][SQ_W:0] ch_pwr;
  logic [PWR_W-1:0]       tot;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [SQ_W-1:0] ie;
    logic signed [SQ_W-1:0] qe;
    logic        [SQ_W-1:0] si;
    logic        [SQ_W-1:0] sq;
    assign ie = {{SAMP_W{i_vec[c][SAMP_W-1]}}, i_vec[c]};
    assign qe = {{SAMP_W{q_vec[c][SAMP_W-1]}}, q_vec[c]};
    assign si = ie * ie;
    assign sq = qe * qe;
    assign ch_pwr[c] = {1'b0, si} + {1'b0, sq};
  end

  always_comb begin
    tot = ch_pwr[0];
    for (int c = 1; c < NCH; c++) begin
      if (boc == MODE_BOC) tot = tot + ch_pwr[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr <= '0;
    end else if (in_valid) begin
      pwr <= tot;
    end
  end

  // R1: channel 1 contributes nothing in single-channel mode
  p_single_ignores_ch1_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid && !boc && i_vec[0] == '0 && q_vec[0] == '0 |=> pwr == '0);

endmodule

// File: rtl/ncoh_pass_ctl.sv
module ncoh_pass_ctl #(
  parameter int NBINS  = 64,
  parameter int PASS_W = 4,
  localparam int BIN_W = $clog2(NBINS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic                  in_pstart,
  input  logic [BIN_W-1:0]      in_bin,
  input  logic [PASS_W-1:0]     n_pass,
  output ncoh_pkg::beat_flags_t s1_flags,
  output logic [BIN_W-1:0]      s1_bin
);
  import ncoh_pkg::*;

  localparam logic [BIN_W-1:0] LAST_BIN = BIN_W'(NBINS - 1);

  logic              active;
  logic [PASS_W-1:0] pcnt;
  logic [PASS_W-1:0] nlim;

  logic              start_new;
  logic              accept;
  logic [PASS_W-1:0] pidx;
  logic [PASS_W-1:0] lim;
  logic              is_last;
  logic              is_end;

  always_comb begin
    start_new = in_valid && in_pstart && !active;
    accept    = start_new || (in_valid && active);
    if (start_new)      pidx = '0;
    else if (in_pstart) pidx = pcnt + 1'b1;
    else                pidx = pcnt;
    if (start_new) lim = (n_pass == '0) ? PASS_W'(1) : n_pass;
    else           lim = nlim;
    is_last = (pidx == lim - 1'b1);
    is_end  = is_last && (in_bin == LAST_BIN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      pcnt     <= '0;
      nlim     <= PASS_W'(1);
      s1_flags <= '0;
      s1_bin   <= '0;
    end else begin
      if (accept) begin
        pcnt   <= pidx;
        active <= !is_end;
      end
      if (start_new) nlim <= lim;
      s1_flags.valid  <= accept;
      s1_flags.first  <= accept && (pidx == '0);
      s1_flags.last   <= accept && is_last;
      s1_flags.pstart <= accept && in_pstart;
      s1_flags.endbin <= accept && is_end;
      if (accept) s1_bin <= in_bin;
    end
  end

  // R5: the pass counter never runs past the sampled pass count
  p_pass_bound_r5: assert property (@(posedge clk) disable iff (rst)
    active |-> pcnt < nlim);

  // R9: an idle beat without pass-start produces no accepted beat
  p_idle_ignore_r9: assert property (@(posedge clk) disable iff (rst)
    !active && in_valid && !in_pstart |=> !s1_flags.valid);

endmodule

// File: rtl/ncoh_acc_ram.sv
module ncoh_acc_ram #(
  parameter int NBINS = 64,
  parameter int PWR_W = 33,
  parameter int ACC_W = 37,
  localparam int BIN_W = $clog2(NBINS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_en,
  input  logic [BIN_W-1:0]      rd_addr,
  input  ncoh_pkg::beat_flags_t s1_flags,
  input  logic [BIN_W-1:0]      s1_bin,
  input  logic [PWR_W-1:0]      s1_pwr,
  output ncoh_pkg::beat_flags_t s2_flags,
  output logic [BIN_W-1:0]      s2_bin,
  output logic [ACC_W-1:0]      s2_sum
);
  import ncoh_pkg::*;

  logic [ACC_W-1:0] mem [NBINS];
  logic [ACC_W-1:0] rdata;
  logic [ACC_W:0]   wide;
  logic [ACC_W-1:0] sum;

  always_comb begin
    wide = {1'b0, rdata} + (ACC_W + 1)'(s1_pwr);
    if (s1_flags.first)  sum = ACC_W'(s1_pwr);
    else if (wide[ACC_W]) sum = '1;
    else                  sum = wide[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rd_en) rdata <= mem[rd_addr];
    if (s1_flags.valid) mem[s1_bin] <= sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_flags <= '0;
      s2_bin   <= '0;
      s2_sum   <= '0;
    end else begin
      s2_flags <= s1_flags;
      if (s1_flags.valid) begin
        s2_bin <= s1_bin;
        s2_sum <= sum;
      end
    end
  end

  // R4: the accumulated value never drops below the beat energy (no wrap)
  p_no_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    s1_flags.valid |=> s2_sum >= ACC_W'($past(s1_pwr)));

  // R3: a first-pass write carries exactly the beat energy
  p_first_clear_r3: assert property (@(posedge clk) disable iff (rst)
    s1_flags.valid && s1_flags.first |=> s2_sum == ACC_W'($past(s1_pwr)));

endmodule

// File: rtl/ncoh_peak.sv
module ncoh_peak #(
  parameter int BIN_W = 6,
  parameter int ACC_W = 37
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s2_valid,
  input  logic             s2_last,
  input  logic             s2_pstart,
  input  logic             s2_endbin,
  input  logic [BIN_W-1:0] s2_bin,
  input  logic [ACC_W-1:0] s2_sum,
  input  logic [ACC_W-1:0] thresh,
  output logic             done,
  output logic [BIN_W-1:0] peak_idx,
  output logic [ACC_W-1:0] peak_val,
  output logic             detect
);

  logic [ACC_W-1:0] best_val;
  logic [BIN_W-1:0] best_idx;
  logic             take;
  logic             finish;
  logic [ACC_W-1:0] nv;
  logic [BIN_W-1:0] ni;

  always_comb begin
    take   = s2_valid && s2_last && (s2_pstart || s2_sum > best_val);
    finish = s2_valid && s2_endbin;
    nv     = take ? s2_sum : best_val;
    ni     = take ? s2_bin : best_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      best_val <= '0;
      best_idx <= '0;
      done     <= 1'b0;
      peak_idx <= '0;
      peak_val <= '0;
      detect   <= 1'b0;
    end else begin
      if (take) begin
        best_val <= s2_sum;
        best_idx <= s2_bin;
      end
      done <= finish;
      if (finish) begin
        peak_idx <= ni;
        peak_val <= nv;
        detect   <= (nv >= thresh);
      end
    end
  end

  // R6: completion is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: results hold between completion pulses
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(peak_idx) && $stable(peak_val) && $stable(detect));

  // R8: the detect flag agrees with the published peak and the threshold
  p_detect_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> detect == (peak_val >= $past(thresh)));

  // R7: the running maximum never falls below a last-pass value
  p_peak_ge_r7: assert property (@(posedge clk) disable iff (rst)
    s2_valid && s2_last |=> best_val >= $past(s2_sum));

endmodule

// File: rtl/ncoh_detect.sv
module ncoh_detect #(
  parameter int NBINS  = 64,
  parameter int SAMP_W = 16,
  parameter int PASS_W = 4,
  parameter int ACC_W  = 37,
  localparam int BIN_W = $clog2(NBINS),
  localparam int PWR_W = 2 * SAMP_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_pass_start,
  input  logic [BIN_W-1:0]  in_bin,
  input  logic              mode_boc,
  input  logic [PASS_W-1:0] n_pass,
  input  logic [ACC_W-1:0]  thresh,
  input  logic [SAMP_W-1:0] ch0_i,
  input  logic [SAMP_W-1:0] ch0_q,
  input  logic [SAMP_W-1:0] ch1_i,
  input  logic [SAMP_W-1:0] ch1_q,
  output logic              done,
  output logic [BIN_W-1:0]  peak_idx,
  output logic [ACC_W-1:0]  peak_val,
  output logic              detect
);
  import ncoh_pkg::*;

  logic [NCH-1:0][SAMP_W-1:0] i_vec;
  logic [NCH-1:0][SAMP_W-1:0] q_vec;
  logic [PWR_W-1:0]           s1_pwr;
  beat_flags_t                s1_flags;
  logic [BIN_W-1:0]           s1_bin;
  beat_flags_t                s2_flags;
  logic [BIN_W-1:0]           s2_bin;
  logic [ACC_W-1:0]           s2_sum;

  assign i_vec = {ch1_i, ch0_i};
  assign q_vec = {ch1_q, ch0_q};

  ncoh_power #(.SAMP_W(SAMP_W)) u_power (
    .clk(clk), .rst(rst), .in_valid(in_valid), .boc(mode_boc),
    .i_vec(i_vec), .q_vec(q_vec), .pwr(s1_pwr)
  );

  ncoh_pass_ctl #(.NBINS(NBINS), .PASS_W(PASS_W)) u_ctl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_pstart(in_pass_start),
    .in_bin(in_bin), .n_pass(n_pass), .s1_flags(s1_flags), .s1_bin(s1_bin)
  );

  ncoh_acc_ram #(.NBINS(NBINS), .PWR_W(PWR_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .rd_en(in_valid), .rd_addr(in_bin),
    .s1_flags(s1_flags), .s1_bin(s1_bin), .s1_pwr(s1_pwr),
    .s2_flags(s2_flags), .s2_bin(s2_bin), .s2_sum(s2_sum)
  );

  ncoh_peak #(.BIN_W(BIN_W), .ACC_W(ACC_W)) u_peak (
    .clk(clk), .rst(rst), .s2_valid(s2_flags.valid), .s2_last(s2_flags.last),
    .s2_pstart(s2_flags.pstart), .s2_endbin(s2_flags.endbin), .s2_bin(s2_bin),
    .s2_sum(s2_sum), .thresh(thresh), .done(done), .peak_idx(peak_idx),
    .peak_val(peak_val), .detect(detect)
  );

endmodule

// File: tb/sim_ncoh_detect.sv
module sim_ncoh_detect;

  localparam int NB    = 16;
  localparam int BW    = 4;
  localparam int ACCW  = 34;
  localparam longint SATV = (64'sd1 <<< ACCW) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic             in_pass_start = 1'b0;
  logic [BW-1:0]    in_bin = '0;
  logic             mode_boc = 1'b0;
  logic [3:0]       n_pass = 4'd1;
  logic [ACCW-1:0]  thresh = '0;
  logic [15:0]      ch0_i = '0, ch0_q = '0, ch1_i = '0, ch1_q = '0;
  logic             done;
  logic [BW-1:0]    peak_idx;
  logic [ACCW-1:0]  peak_val;
  logic             detect;

  always #10 clk = ~clk;

  ncoh_detect #(.NBINS(NB), .ACC_W(ACCW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_pass_start(in_pass_start),
    .in_bin(in_bin), .mode_boc(mode_boc), .n_pass(n_pass), .thresh(thresh),
    .ch0_i(ch0_i), .ch0_q(ch0_q), .ch1_i(ch1_i), .ch1_q(ch1_q),
    .done(done), .peak_idx(peak_idx), .peak_val(peak_val), .detect(detect)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  string cur_tag = "R9";

  // reference model state
  longint acc [NB];
  bit     m_active = 0;
  int     m_pc = 0;
  int     m_nl = 1;
  longint m_best = 0;
  int     m_bidx = 0;

  bit     q_done [$];
  int     q_idx  [$];
  longint q_val  [$];
  bit     q_det  [$];
  string  q_tag  [$];

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit v, bit ps, int bin, bit boc, int i0, int q0, int i1, int q1);
    bit     e_done;
    int     e_idx;
    longint e_val;
    bit     e_det;
    string  e_tag;
    longint p;
    @(negedge clk);
    if (q_done.size() == 3) begin
      e_done = q_done.pop_front();
      e_idx  = q_idx.pop_front();
      e_val  = q_val.pop_front();
      e_det  = q_det.pop_front();
      e_tag  = q_tag.pop_front();
      check(done == e_done, "R6", "done", longint'(done), longint'(e_done));
      if (e_done) begin
        check(int'(peak_idx) == e_idx, "R7", {"peak_idx in ", e_tag}, longint'(peak_idx), longint'(e_idx));
        check(longint'(peak_val) == e_val, e_tag, "peak_val", longint'(peak_val), e_val);
        check(detect == e_det, "R8", "detect", longint'(detect), longint'(e_det));
      end
    end
    in_valid = v; in_pass_start = ps; in_bin = BW'(bin); mode_boc = boc;
    ch0_i = 16'(i0); ch0_q = 16'(q0); ch1_i = 16'(i1); ch1_q = 16'(q1);
    e_done = 0; e_idx = 0; e_val = 0; e_det = 0;
    if (v) begin
      if (ps) begin
        if (!m_active) begin
          m_active = 1; m_pc = 0;
          m_nl = (n_pass == 0) ? 1 : int'(n_pass);
        end else m_pc++;
      end
      if (m_active) begin
        p = longint'(i0) * i0 + longint'(q0) * q0;
        if (boc) p = p + longint'(i1) * i1 + longint'(q1) * q1;
        if (m_pc == 0) acc[bin] = p;
        else begin
          acc[bin] = acc[bin] + p;
          if (acc[bin] > SATV) acc[bin] = SATV;
        end
        if (m_pc == m_nl - 1) begin
          if (ps || acc[bin] > m_best) begin
            m_best = acc[bin]; m_bidx = bin;
          end
          if (bin == NB - 1) begin
            e_done = 1; e_idx = m_bidx; e_val = m_best;
            e_det = (m_best >= longint'(thresh));
            m_active = 0;
          end
        end
      end
    end
    q_done.push_back(e_done); q_idx.push_back(e_idx); q_val.push_back(e_val);
    q_det.push_back(e_det); q_tag.push_back(cur_tag);
  endtask

  function automatic int gen(int kind, int seed, int b, int p, int ch);
    case (kind)
      1: return -32768;
      2: return (b == 5 || b == 9) ? 300 : (b % 4) * 10;
      3: return (b == NB - 1) ? 2000 + p : b * 3 + ch;
      default: return ((seed * 131 + b * 977 + p * 389 + ch * 71) % 4001) - 2000;
    endcase
  endfunction

  task automatic integ(string tag, int np, bit boc, int kind, int seed, longint thr, int gap);
    int passes;
    cur_tag = tag;
    n_pass = 4'(np);
    thresh = ACCW'(thr);
    passes = (np == 0) ? 1 : np;
    for (int p = 0; p < passes; p++) begin
      for (int b = 0; b < NB; b++) begin
        step(1, b == 0, b, boc, gen(kind, seed, b, p, 0), gen(kind, seed + 1, b, p, 1),
             gen(kind, seed + 2, b, p, 2), gen(kind, seed + 3, b, p, 3));
      end
    end
    for (int g = 0; g < gap; g++) step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic junk(int n);
    cur_tag = "R9";
    for (int k = 0; k < n; k++) step(1, 0, k % NB, 1, 20000, -15000, 9000, 7000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check(done == 0, "R9", "reset done", longint'(done), 0);
    check(peak_idx == 0, "R9", "reset peak_idx", longint'(peak_idx), 0);
    check(peak_val == 0, "R9", "reset peak_val", longint'(peak_val), 0);
    check(detect == 0, "R9", "reset detect", longint'(detect), 0);
    junk(5);
    integ("R1", 1, 0, 0, 3, 0, 4);
    integ("R2", 1, 1, 0, 5, 64'd9000000000, 4);
    integ("R3", 3, 0, 0, 7, 5000000, 4);
    integ("R5", 0, 1, 0, 9, 1000, 4);
    junk(7);
    integ("R4", 7, 1, 1, 0, SATV, 4);
    integ("R7", 2, 0, 2, 0, 10, 4);
    integ("R8", 1, 0, 2, 0, 180000, 4);
    integ("R8", 1, 0, 2, 0, 180001, 4);
    // back-to-back: peak on last cell, next integration starts at once
    integ("R10", 2, 1, 3, 0, 50, 0);
    integ("R6", 1, 0, 3, 0, 50, 0);
    integ("R3", 2, 0, 0, 11, 50, 5);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog R6 actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule